// File: doc/BRIEF.md
# Dual-Line Interrupt Expander

This block collects a parameterised set of internal interrupt sources, from 1 to 16, and drives them onto the two interrupt inputs of a processor. One input is a fast line and the other is a normal line. Each source is edge-detected and latched into a sticky pending bit. A per-source route bit picks the line the source drives. A per-source enable bit decides whether a pending source asserts that line. Both output lines are registered.

Software reaches the block through a small synchronous register port with four registers:

| Address | Register | Access |
|---|---|---|
| 0 | enable | read/write |
| 1 | route (1 = fast) | read/write |
| 2 | fast-visibility mask | read/write |
| 3 | status | read; write one to clear |

A status read returns every pending bit of a normal-line source as it is. A pending bit of a fast-line source is returned only when its mask bit is set. This lets the fast handler see only the sources it has chosen to watch, while the normal handler sees every pending bit routed to it.

Top module: `dual_irq_expander`

## Requirements
- R1: After a synchronous reset, enable, route, fast-visibility mask and pending are all zero, and both lines are low. Route zero means the normal line.
- R2: A 0-to-1 change of a source between consecutive clock edges sets its pending bit at the second edge. A source held high does not set the bit again once it has been cleared.
- R3: Writing address 3 clears each pending bit whose data bit is 1 and leaves the others unchanged. Writing 1 never sets a pending bit.
- R4: If a rising edge and a clear of the same bit fall on the same clock edge, the bit stays pending.
- R5: The fast line goes high one clock after some source exists that is pending, enabled and has route bit 1. The line is low otherwise.
- R6: The normal line goes high one clock after some source exists that is pending, enabled and has route bit 0. The line is low otherwise.
- R7: A source with enable 0 still records pending in status, but it never asserts either line.
- R8: Bit i of a status read is pending[i] when route[i] is 0, and pending[i] AND mask[i] when route[i] is 1.
- R9: Addresses 0, 1 and 2 read back the stored enable, route and mask. Bits at or above the source count read 0. Addresses 4 to 7 read 0. Read data appears at the clock edge that samples rd_en high and holds while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Interrupt source levels, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| fast_irq_o | output | 1 | Fast interrupt line |
| norm_irq_o | output | 1 | Normal interrupt line |

## Verification
The bench aims at the asymmetric status read. A fast-routed pending bit must stay hidden until its mask bit is set, and a normal-routed bit must show with the mask clear. A design that masked both lines, or neither, returns the wrong status word. The bench also drives a rising edge into the very cycle that clears the same bit. A design that gives the clear priority loses that interrupt and reads 0 where 0x0020 is expected. It holds a source high across a clear, which catches level-sensitive capture as a bit that reappears. It writes all sixteen data bits, which catches storage above the source count as extra bits read back.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
    localparam int MAX_SRC = 16;
    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 16;

    typedef logic [MAX_SRC-1:0] src_vec_t;

    typedef enum logic [ADDR_W-1:0] {
        SEL_ENABLE = 3'd0,
        SEL_ROUTE  = 3'd1,
        SEL_FMASK  = 3'd2,
        SEL_STATUS = 3'd3
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } host_req_t;

    typedef struct packed {
        src_vec_t enable;
        src_vec_t route;
        src_vec_t fmask;
    } line_cfg_t;

    function automatic src_vec_t valid_bits(input int n);
        src_vec_t v;
        for (int i = 0; i < MAX_SRC; i++) v[i] = (i < n);
        return v;
    endfunction

    function automatic src_vec_t visible_status(input src_vec_t pend,
                                                input src_vec_t route,
                                                input src_vec_t fmask);
        return (pend & route & fmask) | (pend & ~route);
    endfunction
endpackage

// File: rtl/irqx_pend.sv
module irqx_pend
    import irqx_pkg::*;
#(
    parameter int NUM_SRC = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  src_vec_t           clr_i,
    output src_vec_t           pend_o
);
    src_vec_t rise_v;

    for (genvar i = 0; i < MAX_SRC; i++) begin : g_bit
        if (i < NUM_SRC) begin : g_live
            logic src_q;
            logic pend_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    src_q  <= 1'b0;
                    pend_q <= 1'b0;
                end else begin
                    src_q  <= src_i[i];
                    pend_q <= (pend_q & ~clr_i[i]) | rise_v[i];
                end
            end
            assign rise_v[i] = src_i[i] & ~src_q;
            assign pend_o[i] = pend_q;
        end else begin : g_tie
            assign rise_v[i] = 1'b0;
            assign pend_o[i] = 1'b0;
        end
    end

    // R2: a detected edge is pending on the following cycle
    p_rise_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (rise_v != '0) |=> ((pend_o & $past(rise_v)) == $past(rise_v)));

    // R3: a clear without a competing edge empties the bit
    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (clr_i != '0) |=> ((pend_o & $past(clr_i & ~rise_v)) == '0));

    // R4: an edge beats a clear in the same cycle
    p_edge_wins_r4: assert property (@(posedge clk) disable iff (rst)
        ((clr_i & rise_v) != '0) |=>
        ((pend_o & $past(clr_i & rise_v)) == $past(clr_i & rise_v)));
endmodule

// File: rtl/irqx_cfg_regs.sv
module irqx_cfg_regs
    import irqx_pkg::*;
#(
    parameter int NUM_SRC = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  host_req_t         req_i,
    input  src_vec_t          pend_i,
    output line_cfg_t         cfg_o,
    output src_vec_t          clr_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam src_vec_t LIVE = valid_bits(NUM_SRC);

    reg_sel_e  sel;
    src_vec_t  wvec;
    line_cfg_t cfg_q;
    logic [DATA_W-1:0] rd_mux;

    assign sel  = reg_sel_e'(req_i.addr);
    assign wvec = src_vec_t'(req_i.data) & LIVE;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (req_i.wr) begin
            case (sel)
                SEL_ENABLE: cfg_q.enable <= wvec;
                SEL_ROUTE:  cfg_q.route  <= wvec;
                SEL_FMASK:  cfg_q.fmask  <= wvec;
                default:    ;
            endcase
        end
    end

    assign clr_o = (req_i.wr && sel == SEL_STATUS) ? wvec : '0;

    always_comb begin
        case (sel)
            SEL_ENABLE: rd_mux = DATA_W'(cfg_q.enable);
            SEL_ROUTE:  rd_mux = DATA_W'(cfg_q.route);
            SEL_FMASK:  rd_mux = DATA_W'(cfg_q.fmask);
            SEL_STATUS: rd_mux = DATA_W'(visible_status(pend_i, cfg_q.route, cfg_q.fmask));
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)           rdata_o <= '0;
        else if (req_i.rd) rdata_o <= rd_mux;
    end

    assign cfg_o = cfg_q;

    // R1: reset leaves every configuration register empty
    p_reset_cfg_r1: assert property (@(posedge clk)
        rst |=> (cfg_o == '0 && rdata_o == '0));

    // R9: read data holds between reads
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !req_i.rd |=> $stable(rdata_o));

    // R9: unmapped addresses read zero
    p_unmapped_r9: assert property (@(posedge clk) disable iff (rst)
        (req_i.rd && req_i.addr > 3'd3) |=> (rdata_o == '0));

    // R8: fast-routed unmasked bits never show in status
    p_status_mask_r8: assert property (@(posedge clk) disable iff (rst)
        (req_i.rd && sel == SEL_STATUS) |=>
        ((rdata_o & DATA_W'($past(cfg_q.route & ~cfg_q.fmask))) == '0));
endmodule

// File: rtl/irqx_line_merge.sv
module irqx_line_merge
    import irqx_pkg::*;
#(
    parameter int NUM_SRC = 12
) (
    input  logic      clk,
    input  logic      rst,
    input  src_vec_t  pend_i,
    input  line_cfg_t cfg_i,
    output logic      fast_o,
    output logic      norm_o
);
    localparam src_vec_t LIVE = valid_bits(NUM_SRC);

    src_vec_t active;
    src_vec_t fast_terms;
    src_vec_t norm_terms;

    assign active     = pend_i & cfg_i.enable & LIVE;
    assign fast_terms = active & cfg_i.route;
    assign norm_terms = active & ~cfg_i.route;

    always_ff @(posedge clk) begin
        if (rst) begin
            fast_o <= 1'b0;
            norm_o <= 1'b0;
        end else begin
            fast_o <= |fast_terms;
            norm_o <= |norm_terms;
        end
    end

    // R7: nothing enabled means both lines low next cycle
    p_lines_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        ((cfg_i.enable & LIVE) == '0) |=> (!fast_o && !norm_o));

    // R5: no fast route means no fast line
    p_fast_route_r5: assert property (@(posedge clk) disable iff (rst)
        ((cfg_i.route & LIVE) == '0) |=> !fast_o);

    // R6: everything fast-routed means no normal line
    p_norm_route_r6: assert property (@(posedge clk) disable iff (rst)
        ((cfg_i.route & LIVE) == LIVE) |=> !norm_o);
endmodule

// File: rtl/dual_irq_expander.sv
module dual_irq_expander
    import irqx_pkg::*;
#(
    parameter int NUM_SRC = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [2:0]         addr,
    input  logic [15:0]        wdata,
    output logic [15:0]        rdata,
    output logic               fast_irq_o,
    output logic               norm_irq_o
);
    host_req_t req;
    line_cfg_t cfg;
    src_vec_t  clr;
    src_vec_t  pend;

    assign req = '{wr: wr_en, rd: rd_en, addr: addr, data: wdata};

    irqx_pend #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk(clk), .rst(rst), .src_i(src_i), .clr_i(clr), .pend_o(pend)
    );

    irqx_cfg_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk(clk), .rst(rst), .req_i(req), .pend_i(pend),
        .cfg_o(cfg), .clr_o(clr), .rdata_o(rdata)
    );

    irqx_line_merge #(.NUM_SRC(NUM_SRC)) u_merge (
        .clk(clk), .rst(rst), .pend_i(pend), .cfg_i(cfg),
        .fast_o(fast_irq_o), .norm_o(norm_irq_o)
    );
endmodule

// File: tb/tb_dual_irq_expander.sv
module tb_dual_irq_expander;
    localparam int NSRC = 12;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src = '0;
    logic            wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]      addr = '0;
    logic [15:0]     wdata = '0;
    logic [15:0]     rdata;
    logic            fiq, irq;

    int checks = 0, errors = 0, cycles = 0;

    // reference state
    bit [15:0] m_en, m_route, m_mask, m_pend, m_prev, m_rdata;
    bit        m_fiq, m_irq;
    string     rd_tag = "R9";

    dual_irq_expander #(.NUM_SRC(NSRC)) dut (
        .clk(clk), .rst(rst), .src_i(src), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .fast_irq_o(fiq), .norm_irq_o(irq)
    );

    always #5 clk = ~clk;

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model, updated at each rising edge from pre-edge values
    always @(posedge clk) begin
        bit [15:0] rise, clr;
        bit nf, nn;
        if (rst) begin
            m_en = 0; m_route = 0; m_mask = 0; m_pend = 0; m_prev = 0;
            m_rdata = 0; m_fiq = 0; m_irq = 0;
        end else begin
            nf = 0; nn = 0; clr = 0;
            for (int i = 0; i < 16; i++) begin
                rise[i] = (i < NSRC) && src[i % NSRC] && !m_prev[i];
                if (m_pend[i] && m_en[i]) begin
                    if (m_route[i]) nf = 1; else nn = 1;
                end
            end
            if (rd_en) begin
                case (addr)
                    3'd0: m_rdata = m_en;
                    3'd1: m_rdata = m_route;
                    3'd2: m_rdata = m_mask;
                    3'd3: for (int i = 0; i < 16; i++)
                              m_rdata[i] = m_pend[i] && (!m_route[i] || m_mask[i]);
                    default: m_rdata = 0;
                endcase
                rd_tag = (addr == 3'd3) ? "R8" : "R9";
            end
            if (wr_en) begin
                for (int i = 0; i < 16; i++) begin
                    if (i < NSRC) begin
                        case (addr)
                            3'd0: m_en[i]    = wdata[i];
                            3'd1: m_route[i] = wdata[i];
                            3'd2: m_mask[i]  = wdata[i];
                            3'd3: clr[i]     = wdata[i];
                            default: ;
                        endcase
                    end
                end
            end
            for (int i = 0; i < 16; i++) begin
                m_pend[i] = (m_pend[i] && !clr[i]) || rise[i];
                m_prev[i] = (i < NSRC) && src[i % NSRC];
            end
            m_fiq = nf; m_irq = nn;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check({15'd0, fiq}, {15'd0, m_fiq}, "R5 model");
            check({15'd0, irq}, {15'd0, m_irq}, "R6 model");
            check(rdata, m_rdata, rd_tag);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++; checks++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk); rd_en = 1; addr = a;
        @(negedge clk); rd_en = 0; v = rdata;
    endtask

    task automatic pulse(input int i);
        @(negedge clk); src[i] = 1;
        @(negedge clk); src[i] = 0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        logic [15:0] v;
        idle(3); rst = 0; idle(1);
        // R1 reset state
        check({15'd0, fiq}, 16'd0, "R1 fast line");
        check({15'd0, irq}, 16'd0, "R1 normal line");
        for (int a = 0; a < 4; a++) begin
            rd(3'(a), v); check(v, 16'h0000, "R1 register");
        end
        // R9 storage width and readback
        wr(0, 16'hFFFF); rd(0, v); check(v, 16'h0FFF, "R9 enable width");
        wr(0, 16'h0000);
        wr(1, 16'h8000); rd(1, v); check(v, 16'h0000, "R9 route upper bit");
        wr(2, 16'h0A5A); rd(2, v); check(v, 16'h0A5A, "R9 mask readback");
        wr(2, 16'h0000);
        // R2/R7 edge recorded while disabled
        pulse(3); idle(2);
        check({15'd0, fiq | irq}, 16'd0, "R7 disabled source lines");
        rd(3, v); check(v, 16'h0008, "R2 edge sets pending");
        // R8 asymmetric visibility
        wr(1, 16'h0008); rd(3, v); check(v, 16'h0000, "R8 fast bit hidden");
        wr(2, 16'h0008); rd(3, v); check(v, 16'h0008, "R8 fast bit shown");
        // R3 clear only written ones
        wr(3, 16'h0001); rd(3, v); check(v, 16'h0008, "R3 other bit untouched");
        // R5 fast line
        wr(0, 16'h0008); idle(1);
        check({15'd0, fiq}, 16'd1, "R5 fast line high");
        check({15'd0, irq}, 16'd0, "R6 normal line low");
        wr(3, 16'h0008); idle(1);
        rd(3, v); check(v, 16'h0000, "R3 clear");
        check({15'd0, fiq}, 16'd0, "R5 fast line low");
        wr(3, 16'h0010); rd(3, v); check(v, 16'h0000, "R3 write does not set");
        // R2 level held does not re-set
        @(negedge clk); src[1] = 1; idle(2);
        rd(3, v); check(v, 16'h0002, "R2 level pending");
        wr(3, 16'h0002); rd(3, v); check(v, 16'h0000, "R2 held level no re-set");
        @(negedge clk); src[1] = 0;
        // R6 normal line
        wr(0, 16'h000A); pulse(1); idle(2);
        check({15'd0, irq}, 16'd1, "R6 normal line high");
        check({15'd0, fiq}, 16'd0, "R5 fast line stays low");
        wr(3, 16'h0002); idle(1);
        check({15'd0, irq}, 16'd0, "R6 normal line low");
        // R4 coincident edge and clear
        pulse(5); idle(1);
        @(negedge clk); src[5] = 1; wr_en = 1; addr = 3; wdata = 16'h0020;
        @(negedge clk); wr_en = 0; src[5] = 0;
        rd(3, v); check(v, 16'h0020, "R4 edge wins over clear");
        wr(3, 16'h0020); rd(3, v); check(v, 16'h0000, "R4 later clear");
        // R9 unmapped
        rd(5, v); check(v, 16'h0000, "R9 unmapped read");
        idle(3);
        check(rdata, 16'h0000, "R9 rdata holds");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule